// File: doc/BRIEF.md
# Synthesizer Programming Word Loader

This block keeps the programming word of a frequency synthesizer: a 7-bit feedback count, a 2-bit output divide select and a 3-bit test field. Two paths write it. A parallel path copies the count and divide pins into the output latches while a parallel-load level is high; it is meant for setting the word at power-up. A three-wire serial path shifts one data bit per rising edge of a shift clock into a 12-bit chain. A load strobe then moves the chain contents into the latches.

All inputs are sampled in one system clock domain. The serial data, shift clock and load strobe first pass through a synchronizer of `SYNC_STAGES` flops. A rising edge of the shift clock is found after that synchronizer. The latches are registers: while a load source is active, they copy that source on every system clock edge, and otherwise they hold.

Top module: `synth_cfg_load`

## Requirements
- R1: A synchronous reset (`rst` high) clears the feedback count, the divide select, the test field and the whole serial chain to zero.
- R2: While `pload` is high, `m_out` and `n_out` take the values of `m_pin` and `n_pin` at the next system clock edge.
- R3: While `pload` is high, the serial load strobe has no effect: `m_out` and `n_out` follow the pins and `test_out` keeps its value.
- R4: Serial bits enter most significant bit first, in the order test[2:0], N[1:0], M[6:0]. After 12 shifts and a load, `test_out`, `n_out` and `m_out` equal those fields.
- R5: While `pload` and the synchronized load strobe are both low, all three outputs hold, even while bits are shifted.
- R6: While the synchronized load strobe is high and `pload` is low, the outputs track the chain. Each further shift appears on the outputs one system clock later, and the newest bit becomes M bit 0.
- R7: The chain shifts exactly once for each rising edge of the shift clock. A shift clock that stays high does not shift again.
- R8: When more than 12 bits are shifted in, the earliest bits leave the far end, and only the last 12 bits are loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pload | input | 1 | Parallel-load level; selects the pins as the latch source |
| m_pin | input | 7 | Parallel feedback count value |
| n_pin | input | 2 | Parallel divide select value |
| sdata | input | 1 | Serial data bit |
| sclk | input | 1 | Serial shift clock; a shift happens on its rising edge |
| sload | input | 1 | Serial load strobe; the latches track the chain while it is high |
| m_out | output | 7 | Latched feedback count |
| n_out | output | 2 | Latched divide select |
| test_out | output | 3 | Latched test field |

## Verification
Some rules are checked by the assertions on every cycle. These are the cycle-level rules: the zero state right after reset, the pins copied under parallel load, the test field held under parallel load, the hold when no source is active, the latches tracking the chain under the strobe, and the single-bit shift step. Other behaviour shows only in the bench's scenarios. This covers the bit order across a full 12-shift word, the loss of early bits on overflow, and the single shift for a long-held shift clock. It also covers the proof that a serial load made during parallel load is really lost. Each of these depends on a whole sequence of stimulus, not on one clock step.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

    localparam int M_W    = 7;
    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int WORD_W = T_W + N_W + M_W;

    // Field order matches the serial shift order (first bit shifted = MSB).
    typedef struct packed {
        logic [T_W-1:0] test;
        logic [N_W-1:0] ndiv;
        logic [M_W-1:0] mcnt;
    } cfg_word_t;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_PINS  = 2'd1,
        SRC_CHAIN = 2'd2
    } latch_src_e;

    // Parallel load has priority over the serial strobe.
    function automatic latch_src_e pick_source(input logic par, input logic ser);
        if (par)
            return SRC_PINS;
        else if (ser)
            return SRC_CHAIN;
        else
            return SRC_HOLD;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stg [STAGES];
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        stg[s] <= '0;
                    else if (s == 0)
                        stg[s] <= d;
                    else
                        stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain
    import cfgload_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              data_s,
    output logic              shift_en,
    output logic [WORD_W-1:0] chain_q
);

    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst)
            sclk_prev <= 1'b0;
        else
            sclk_prev <= sclk_s;
    end

    assign shift_en = sclk_s & ~sclk_prev;

    // Bit 0 is nearest the input; bits move toward WORD_W-1 on each shift.
    generate
        for (genvar i = 0; i < WORD_W; i++) begin : g_bit
            logic nxt;
            if (i == 0) begin : g_head
                assign nxt = data_s;
            end else begin : g_body
                assign nxt = chain_q[i-1];
            end
            always_ff @(posedge clk) begin
                if (rst)
                    chain_q[i] <= 1'b0;
                else if (shift_en)
                    chain_q[i] <= nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
    import cfgload_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  latch_src_e     src,
    input  logic [M_W-1:0] m_pin,
    input  logic [N_W-1:0] n_pin,
    input  cfg_word_t      chain_word,
    output cfg_word_t      q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (src)
                SRC_PINS: begin
                    q.mcnt <= m_pin;
                    q.ndiv <= n_pin;
                end
                SRC_CHAIN: q <= chain_word;
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/synth_cfg_load.sv
module synth_cfg_load
    import cfgload_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pload,
    input  logic [M_W-1:0] m_pin,
    input  logic [N_W-1:0] n_pin,
    input  logic           sdata,
    input  logic           sclk,
    input  logic           sload,
    output logic [M_W-1:0] m_out,
    output logic [N_W-1:0] n_out,
    output logic [T_W-1:0] test_out
);

    localparam int SER_W = 3;

    logic [SER_W-1:0]  ser_s;
    logic              data_s;
    logic              sclk_s;
    logic              sload_s;
    logic              shift_en;
    logic [WORD_W-1:0] chain_q;
    cfg_word_t         chain_word;
    cfg_word_t         latched;
    latch_src_e        src;

    cfg_sync #(.W(SER_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sdata, sclk, sload}),
        .q   (ser_s)
    );

    assign {data_s, sclk_s, sload_s} = ser_s;

    cfg_shift_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (sclk_s),
        .data_s   (data_s),
        .shift_en (shift_en),
        .chain_q  (chain_q)
    );

    assign chain_word = cfg_word_t'(chain_q);
    assign src        = pick_source(pload, sload_s);

    cfg_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .m_pin      (m_pin),
        .n_pin      (n_pin),
        .chain_word (chain_word),
        .q          (latched)
    );

    assign m_out    = latched.mcnt;
    assign n_out    = latched.ndiv;
    assign test_out = latched.test;

endmodule

// File: rtl/synth_cfg_load_chk.sv
module synth_cfg_load_chk
    import cfgload_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pload,
    input logic [M_W-1:0]    m_pin,
    input logic [N_W-1:0]    n_pin,
    input logic [M_W-1:0]    m_out,
    input logic [N_W-1:0]    n_out,
    input logic [T_W-1:0]    test_out,
    input logic              sload_s,
    input logic              shift_en,
    input logic              data_s,
    input logic [WORD_W-1:0] chain_q
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (m_out == '0 && n_out == '0 && test_out == '0 && chain_q == '0)); // R1

    AST_PINS_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        pload |=> (m_out == $past(m_pin) && n_out == $past(n_pin))); // R2

    AST_TEST_KEPT_PLOAD: assert property (@(posedge clk) disable iff (rst)
        pload |=> $stable(test_out)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!pload && !sload_s) |=> ($stable(m_out) && $stable(n_out) && $stable(test_out))); // R5

    AST_TRACK_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (!pload && sload_s) |=> ({test_out, n_out, m_out} == $past(chain_q))); // R6

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (chain_q == {$past(chain_q[WORD_W-2:0]), $past(data_s)})); // R7

    AST_NO_SHIFT_STILL: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain_q)); // R7

endmodule

bind synth_cfg_load synth_cfg_load_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pload    (pload),
    .m_pin    (m_pin),
    .n_pin    (n_pin),
    .m_out    (m_out),
    .n_out    (n_out),
    .test_out (test_out),
    .sload_s  (sload_s),
    .shift_en (shift_en),
    .data_s   (data_s),
    .chain_q  (chain_q)
);

// File: tb/synth_cfg_load_tb.sv
module synth_cfg_load_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pload = 1'b0;
    logic [6:0] m_pin = '0;
    logic [1:0] n_pin = '0;
    logic       sdata = 1'b0;
    logic       sclk = 1'b0;
    logic       sload = 1'b0;
    logic [6:0] m_out;
    logic [1:0] n_out;
    logic [2:0] test_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] model_chain = '0;
    logic [11:0] model_out   = '0;

    always #4 clk = ~clk;

    synth_cfg_load u_dut (
        .clk(clk), .rst(rst), .pload(pload), .m_pin(m_pin), .n_pin(n_pin),
        .sdata(sdata), .sclk(sclk), .sload(sload),
        .m_out(m_out), .n_out(n_out), .test_out(test_out)
    );

    // Entry: bit 12 = 1 serial word load, 0 parallel load of word[8:7]/word[6:0].
    localparam logic [12:0] VEC [0:5] = '{
        {1'b1, 12'hA5C}, {1'b0, 12'h1FF}, {1'b1, 12'hFFF},
        {1'b0, 12'h0A3}, {1'b1, 12'h000}, {1'b1, 12'h5A5}
    };

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [11:0] exp);
        logic [11:0] got;
        got = {test_out, n_out, m_out};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %03h expected %03h", req, got, exp);
        end
    endtask

    task automatic shift_bit(input logic b, input int high_cycles);
        sdata = b;
        wait_neg(2);
        sclk = 1'b1;
        wait_neg(high_cycles);
        sclk = 1'b0;
        wait_neg(5);
        model_chain = {model_chain[10:0], b};
    endtask

    task automatic shift_word(input logic [11:0] w);
        for (int i = 11; i >= 0; i--) shift_bit(w[i], 5);
    endtask

    task automatic pulse_load();
        sload = 1'b1;
        wait_neg(6);
        sload = 1'b0;
        wait_neg(6);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_neg(3);
        rst = 1'b0;
        wait_neg(1);
        model_chain = '0;
        model_out   = '0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_neg(1);
        do_reset();
        check("R1 reset state", 12'h000);

        // Table walk: serial loads (R4) and parallel loads (R2)
        for (int v = 0; v < 6; v++) begin
            if (VEC[v][12]) begin
                shift_word(VEC[v][11:0]);
                check("R5 hold before strobe", model_out);
                pulse_load();
                model_out = model_chain;
                check("R4 serial word", model_out);
            end else begin
                m_pin = VEC[v][6:0];
                n_pin = VEC[v][8:7];
                pload = 1'b1;
                wait_neg(2);
                pload = 1'b0;
                wait_neg(2);
                model_out = {model_out[11:9], VEC[v][8:0]};
                check("R2 parallel capture", model_out);
            end
        end

        // R3: serial load during parallel load is lost, test kept
        m_pin = 7'h2B; n_pin = 2'b10;
        pload = 1'b1;
        shift_word(12'h3C7);
        pulse_load();
        model_out = {model_out[11:9], 2'b10, 7'h2B};
        check("R3 pins win over strobe", model_out);
        pload = 1'b0;
        wait_neg(6);
        check("R3 no late serial load", model_out);

        // R6: strobe held high, outputs track each shift
        sload = 1'b1;
        wait_neg(6);
        model_out = model_chain;
        check("R6 track on strobe rise", model_out);
        shift_bit(1'b1, 5);
        model_out = model_chain;
        check("R6 track new bit", model_out);
        shift_bit(1'b0, 5);
        model_out = model_chain;
        check("R6 track second bit", model_out);

        // R7: shift clock held high for a long time shifts once
        shift_bit(1'b1, 40);
        model_out = model_chain;
        check("R7 single shift", model_out);
        sload = 1'b0;
        wait_neg(6);

        // R8: fifteen bits, only the last twelve kept
        shift_bit(1'b1, 5); shift_bit(1'b1, 5); shift_bit(1'b0, 5);
        shift_word(12'h6D2);
        pulse_load();
        model_out = model_chain;
        check("R8 last twelve bits", 12'h6D2);

        // R1: reset mid-operation clears outputs and chain
        do_reset();
        check("R1 reset clears outputs", 12'h000);
        pulse_load();
        check("R1 reset clears chain", 12'h000);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule